// File: doc/BRIEF.md
# SPI Master Word Engine

This block runs full-duplex word exchanges with a single peripheral over a four-wire synchronous serial link. A transmit word enters on a valid/ready stream; the engine pulls its active-low select down, generates the serial clock from the system clock and shifts the word out on MOSI. In the same clock cycles it samples MISO. When the last bit has moved, it returns the received word on an output stream as a one-cycle pulse. The serial clock is a register in the system clock domain. Its half-period is a run-time count of system clocks.

Idle polarity, data phase, bit order, half-period and a setup delay are plain configuration inputs. They are captured when the first word of a burst is accepted. A word that carries `in_last` = 0 keeps select low. The engine then waits with `in_ready` high for the next word, which reloads the shift register with no select pulse.

Input stream rules: `in_data` and `in_last` must stay stable while `in_valid` is high. A word is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high only when the engine is idle or is holding select between burst words. The output stream has no back-pressure: `out_valid` is high for exactly one cycle and `out_data` is valid only in that cycle.

Top module: `spi_stream_master`

## Requirements
- R1: While select is high, SCLK rests at the `cfg_cpol` level (0 = low, 1 = high). The mode number is {cpol, cpha}.
- R2: With `cfg_cpha` = 0, MOSI carries the first bit in the cycle select falls. Later bits change on edges back toward the rest level, and MISO is sampled on edges away from it.
- R3: With `cfg_cpha` = 1, MOSI stays 0 until the first SCLK edge, which drives the first bit. Bits change on edges away from rest, and MISO is sampled on edges back toward rest.
- R4: Each word moves W bits in both directions. The peripheral receives `in_data`, and `out_data` holds the W bits sampled from MISO.
- R5: With `cfg_lsb_first` = 0, bit W-1 travels first. With 1, bit 0 travels first. `out_data` places received bits by the same order.
- R6: Every SCLK half-period lasts `cfg_half_div` system clocks. A value of 0 acts as 1.
- R7: The first SCLK edge of a burst comes (`cfg_setup_halves`+1) half-periods after the clock edge at which select falls. The first edge of a later burst word comes one half-period after that word is accepted.
- R8: After a word with `in_last` = 0, select stays low and `in_ready` goes high, waiting for the next word.
- R9: `busy` is high exactly while select is low. `in_ready` is low while a word is in setup or shifting, so `in_valid` has no effect then.
- R10: Each finished word gives exactly one single-cycle `out_valid` pulse.
- R11: For a word with `in_last` = 1, select rises in the same cycle as the final SCLK edge back to rest and the `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cpol | input | 1 | SCLK rest level |
| cfg_cpha | input | 1 | Data phase select |
| cfg_lsb_first | input | 1 | Send and receive bit 0 first |
| cfg_half_div | input | DIVW | System clocks per SCLK half-period |
| cfg_setup_halves | input | SETW | Idle half-periods after select falls |
| in_valid | input | 1 | Transmit word offered |
| in_ready | output | 1 | Transmit word can be taken |
| in_data | input | W | Transmit word |
| in_last | input | 1 | Release select after this word |
| out_valid | output | 1 | Received word pulse |
| out_data | output | W | Received word |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Peripheral select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events share a clock edge. On the final SCLK edge of a word, the engine samples the last MISO bit (in phase-1 modes), raises `out_valid` with that bit already in `out_data`, and, for a closing word, releases select. This is provoked in all four modes and both bit orders. It is judged by a behavioural peripheral model, which checks that the returned word is complete and that select rises in the pulse cycle. In bursts, the next word is held on the input stream before the current word ends. The model then checks that acceptance happens in the cycle after the pulse and that the first edge of the new word is one half-period later.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } spim_state_e;
endpackage

// File: rtl/spim_bitrev.sv
module spim_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] lim;

  assign lim  = (half == '0) ? '0 : half - 1'b1;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R6: with a half-period above one clock, ticks never fall on adjacent cycles
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && lim != '0) |=> !tick);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         cpha,
  input  logic         edge_en,
  input  logic         miso,
  output logic         mosi,
  output logic         last_edge,
  output logic [W-1:0] rx_word
);
  localparam int CW = $clog2(2 * W);
  localparam logic [CW-1:0] LAST_E = CW'(2 * W - 1);

  logic [W-1:0]  txsh, rxsh;
  logic [CW-1:0] ecnt;
  logic          mosi_q;
  logic          lead, drive, samp;

  assign lead      = ~ecnt[0];
  assign drive     = cpha ? lead : (!lead && ecnt != LAST_E);
  assign samp      = cpha ? !lead : lead;
  assign last_edge = edge_en && (ecnt == LAST_E);
  assign rx_word   = (edge_en && samp) ? {rxsh[W-2:0], miso} : rxsh;
  assign mosi      = mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txsh   <= '0;
      rxsh   <= '0;
      ecnt   <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      txsh   <= cpha ? load_word : {load_word[W-2:0], 1'b0};
      mosi_q <= cpha ? 1'b0 : load_word[W-1];
      ecnt   <= '0;
    end else if (edge_en) begin
      if (drive) begin
        mosi_q <= txsh[W-1];
        txsh   <= {txsh[W-2:0], 1'b0};
      end
      if (samp) rxsh <= {rxsh[W-2:0], miso};
      ecnt <= ecnt + 1'b1;
    end
  end

  // R4: a reload never coincides with a serial clock edge
  a_r4_load_apart: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !edge_en);
endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
  import spim_pkg::*;
#(
  parameter int W    = 8,
  parameter int DIVW = 8,
  parameter int SETW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_lsb_first,
  input  logic [DIVW-1:0] cfg_half_div,
  input  logic [SETW-1:0] cfg_setup_halves,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_data,
  input  logic            in_last,
  output logic            out_valid,
  output logic [W-1:0]    out_data,
  output logic            busy,
  output logic            sclk,
  output logic            cs_n,
  output logic            mosi,
  input  logic            miso
);
  spim_state_e     state;
  logic            cpha_q, lsb_q, last_q;
  logic [DIVW-1:0] half_q;
  logic [SETW-1:0] scnt;
  logic            sclk_q, cs_n_q, ov_q;
  logic [W-1:0]    od_q;

  logic            accept, run, tick, edge_en, last_edge;
  logic            cpha_sel, lsb_sel;
  logic [W-1:0]    tx_rev, tx_word, rx_word, rx_rev;

  assign in_ready  = (state == ST_IDLE) || (state == ST_GAP);
  assign accept    = in_valid && in_ready;
  assign cpha_sel  = (state == ST_IDLE) ? cfg_cpha : cpha_q;
  assign lsb_sel   = (state == ST_IDLE) ? cfg_lsb_first : lsb_q;
  assign tx_word   = lsb_sel ? tx_rev : in_data;
  assign run       = (state == ST_SETUP) || (state == ST_SHIFT);
  assign edge_en   = tick && (state == ST_SHIFT);

  assign busy      = (state != ST_IDLE);
  assign sclk      = sclk_q;
  assign cs_n      = cs_n_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  spim_bitrev #(.W(W)) u_txrev (.din(in_data), .dout(tx_rev));
  spim_bitrev #(.W(W)) u_rxrev (.din(rx_word), .dout(rx_rev));

  spim_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half_q), .tick(tick)
  );

  spim_shifter #(.W(W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_word(tx_word),
    .cpha(cpha_sel), .edge_en(edge_en), .miso(miso), .mosi(mosi),
    .last_edge(last_edge), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
      last_q <= 1'b1;
      half_q <= '0;
      scnt   <= '0;
      sclk_q <= cfg_cpol;
      cs_n_q <= 1'b1;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else begin
      ov_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclk_q <= cfg_cpol;
          if (accept) begin
            cpha_q <= cfg_cpha;
            lsb_q  <= cfg_lsb_first;
            half_q <= cfg_half_div;
            last_q <= in_last;
            cs_n_q <= 1'b0;
            scnt   <= cfg_setup_halves;
            state  <= (cfg_setup_halves == '0) ? ST_SHIFT : ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            scnt <= scnt - 1'b1;
            if (scnt == SETW'(1)) state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (last_edge) begin
              ov_q  <= 1'b1;
              od_q  <= lsb_q ? rx_rev : rx_word;
              if (last_q) begin
                cs_n_q <= 1'b1;
                state  <= ST_IDLE;
              end else begin
                state  <= ST_GAP;
              end
            end
          end
        end
        ST_GAP: begin
          if (accept) begin
            last_q <= in_last;
            state  <= ST_SHIFT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: rest level follows the polarity input while deselected
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_q && $past(cs_n_q)) |-> (sclk_q == $past(cfg_cpol)));

  // R2: phase-0 first bit is on MOSI in the cycle select falls
  a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_q) && !cpha_q) |->
      (mosi == ($past(cfg_lsb_first) ? $past(in_data[0]) : $past(in_data[W-1]))));

  // R8: a non-final word keeps select low when it completes
  a_r8_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !last_q) |-> !cs_n_q);

  // R9: busy tracks select
  a_r9_busy_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n_q);

  // R10: completion pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |=> !ov_q);

  // R11: select rises together with the completion pulse
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> ov_q);
endmodule

// File: tb/tb_spi_stream_master.sv
`timescale 1ns/1ps
module tb_spi_stream_master;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic [7:0] cfg_half_div;
  logic [3:0] cfg_setup_halves;
  logic in_valid, in_ready, in_last;
  logic [W-1:0] in_data;
  logic out_valid, busy, sclk, cs_n, mosi;
  logic [W-1:0] out_data;
  logic miso = 1'b0;

  always #2 clk = ~clk;

  spi_stream_master #(.W(W), .DIVW(8), .SETW(4)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_half_div(cfg_half_div),
    .cfg_setup_halves(cfg_setup_halves), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_data(out_data), .busy(busy), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int sent   = 0;
  logic [W-1:0] mtx_q[$];
  bit           last_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sword(input int i);
    return W'((i * 37 + 91) ^ 195);
  endfunction

  function automatic logic bit_at(input logic [W-1:0] w, input int k, input logic lsb);
    return lsb ? w[k] : w[W-1-k];
  endfunction

  // behavioural peripheral and per-cycle comparison
  logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_ov = 1'b0, prev_cpol = 1'b0;
  logic [W-1:0] s_tx, s_rx;
  int s_edges = 0, s_idx = 0, o_idx = 0;
  int a_cyc = 0, first_exp = 0, last_e = 0;
  bit first_pend = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int h;
      logic [W-1:0] mw;
      h  = (cfg_half_div == 0) ? 1 : int'(cfg_half_div);
      mw = (mtx_q.size() > 0) ? mtx_q[0] : '0;
      if (cs_n && cfg_cpol == prev_cpol) chk("R1 rest level", sclk, cfg_cpol);
      chk("R9 busy vs select", busy, !cs_n);
      if (prev_cs && !cs_n) begin
        s_tx = sword(s_idx);
        s_edges = 0;
        s_rx = '0;
        if (!cfg_cpha) begin
          miso = bit_at(s_tx, 0, cfg_lsb_first);
          chk("R2 first bit at select", mosi, bit_at(mw, 0, cfg_lsb_first));
        end else begin
          chk("R3 mosi quiet before edge", mosi, 0);
        end
      end
      if (sclk != prev_sclk && (!cs_n || !prev_cs)) begin
        bit lead;
        int k;
        lead = (sclk != cfg_cpol);
        k = s_edges;
        if (first_pend) begin
          chk("R7 first edge delay", cyc - a_cyc, first_exp);
          first_pend = 0;
        end else begin
          chk("R6 half period", cyc - last_e, h);
        end
        last_e = cyc;
        if (cfg_cpha ? !lead : lead)
          s_rx[cfg_lsb_first ? k / 2 : W - 1 - k / 2] = mosi;
        if (cfg_cpha && lead) begin
          miso = bit_at(s_tx, k / 2, cfg_lsb_first);
          if (k == 0) chk("R3 first bit on first edge", mosi, bit_at(mw, 0, cfg_lsb_first));
        end
        if (!cfg_cpha && !lead && k < 2 * W - 1)
          miso = bit_at(s_tx, (k + 1) / 2, cfg_lsb_first);
        s_edges++;
        if (s_edges == 2 * W) begin
          if (mtx_q.size() == 0) chk("R4 unexpected word", 1, 0);
          else chk(cfg_lsb_first ? "R5 peripheral got word" : "R4 peripheral got word",
                   s_rx, mtx_q.pop_front());
          s_idx++;
          s_tx = sword(s_idx);
          s_edges = 0;
          s_rx = '0;
          if (!cfg_cpha) miso = bit_at(s_tx, 0, cfg_lsb_first);
        end
      end
      if (out_valid) begin
        chk("R10 single pulse", prev_ov, 0);
        chk(cfg_lsb_first ? "R5 out_data" : "R4 out_data", out_data, sword(o_idx));
        o_idx++;
        if (last_q.size() == 0) chk("R10 extra pulse", 1, 0);
        else if (last_q.pop_front()) chk("R11 select released", cs_n, 1);
        else begin
          chk("R8 select held", cs_n, 0);
          chk("R8 ready between words", in_ready, 1);
        end
      end
      if (in_valid && in_ready) begin
        a_cyc = cyc + 1;
        first_exp = (cs_n ? int'(cfg_setup_halves) + 1 : 1) * h;
        first_pend = 1;
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
    prev_ov   = out_valid;
    prev_cpol = cfg_cpol;
  end

  task automatic setcfg(input logic p, input logic ph, input logic l,
                        input logic [7:0] d, input logic [3:0] s);
    @(posedge clk); #1;
    cfg_cpol = p; cfg_cpha = ph; cfg_lsb_first = l;
    cfg_half_div = d; cfg_setup_halves = s;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [W-1:0] w, input logic last);
    mtx_q.push_back(w);
    last_q.push_back(last);
    sent++;
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = w; in_last = last;
    while (!in_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b1;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
    cfg_half_div = 8'd2; cfg_setup_halves = 4'd1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset select", cs_n, 1);
    chk("R9 reset busy", busy, 0);
    chk("R10 reset pulse", out_valid, 0);
    chk("R9 reset ready", in_ready, 1);
    chk("R1 reset rest level", sclk, 0);

    // all four modes, both bit orders, varied divider and setup
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 2; l++) begin
        setcfg(m[1], m[0], l[0], 8'(m + 1), 4'(m));
        send(8'hA5 ^ 8'(m * 16 + l * 3), 1'b1);
        wait_idle();
      end
    end

    // R6: zero divider acts as one
    setcfg(1'b0, 1'b0, 1'b0, 8'd0, 4'd0);
    send(8'h81, 1'b1);
    wait_idle();

    // R8: bursts with select held
    setcfg(1'b0, 1'b1, 1'b0, 8'd2, 4'd2);
    send(8'h3E, 1'b0);
    send(8'hC1, 1'b0);
    send(8'h5A, 1'b1);
    wait_idle();
    setcfg(1'b1, 1'b0, 1'b1, 8'd1, 4'd0);
    send(8'h01, 1'b0);
    send(8'hF0, 1'b1);
    wait_idle();

    // R9: offers while busy are not taken
    setcfg(1'b1, 1'b1, 1'b0, 8'd3, 4'd1);
    send(8'h3C, 1'b1);
    for (int j = 0; j < 6; j++) begin
      in_valid = 1'b1; in_data = 8'hFF; in_last = 1'b1;
      chk("R9 ready low while shifting", in_ready, 0);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    wait_idle();

    chk("R4 words at peripheral", s_idx, sent);
    chk("R10 pulse count", o_idx, sent);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule